// File: doc/BRIEF.md
# Burst Address Generator with Dual Strobes

This block produces the address sequence for a synchronous burst memory. A starting address is captured from the address input when one of two active-low load strobes takes effect. The controller-side strobe always loads. The processor-side strobe loads only while the chip select is high. After the load, the two low address bits step through a four-beat burst, one beat for each clock edge at which the active-low advance input is low. The bits above them keep the captured value for the whole burst.

A mode input chooses the beat ordering. In linear order the low bits count up from the start and wrap inside the aligned four-word block. In interleaved order the low bits are the start value XOR the beat index. The block outputs the full current address, the beat index and a flag that marks the last beat. This fits the usual one-slow-plus-three-fast access pattern of pipelined burst memories. All inputs, including the mode, are registered on the rising clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low and after it is released, before any load, addr_o is zero, beat_o is 0 and last_o is 0.
- R2: When strobe_c_ni is low at a rising edge, addr_i is captured whatever chip_sel_i is. From the next cycle addr_o equals addr_i and beat_o is 0.
- R3: When strobe_p_ni is low and strobe_c_ni is high at an edge, addr_i is captured only if chip_sel_i is 1. With chip_sel_i at 0, addr_o and beat_o behave as if no strobe were active.
- R4: With no load and adv_ni low at an edge, beat_o increases by one when it is below 3.
- R5: With no load and adv_ni high at an edge, beat_o and addr_o keep their values.
- R6: A load at an edge takes priority over a simultaneous advance, so beat_o becomes 0.
- R7: Once beat_o is 3, further advances leave beat_o and addr_o unchanged until the next load.
- R8: When mode_i was 0 (linear) at the last edge, addr_o[1:0] equals (start[1:0] + beat_o) mod 4.
- R9: When mode_i was 1 (interleaved) at the last edge, addr_o[1:0] equals start[1:0] XOR beat_o.
- R10: addr_o bits above bit 1 equal the bits captured at the last load for every beat.
- R11: last_o is 1 exactly when beat_o is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Start address offered for capture |
| strobe_p_ni | input | 1 | Processor-side load strobe, active low, qualified by chip_sel_i |
| strobe_c_ni | input | 1 | Controller-side load strobe, active low, unqualified |
| chip_sel_i | input | 1 | Chip select, active high, gates the processor strobe |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Index of the current beat, 0 to 3 |
| last_o | output | 1 | High on the fourth beat |

## Verification
Every result arrives one cycle after the stimulus that causes it: a load, an advance or a mode change at one rising edge is visible on addr_o, beat_o and last_o just after that edge, with no further delay. The bench changes inputs on the falling edge. It updates its own model of start address, beat and mode at the rising edge and compares all three outputs one nanosecond later, before the next input change. All four start offsets are run in both orders through a full burst and one advance past the end. Random strobes, selects, advances and mode changes are then checked in every cycle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/strobe_decode.sv
module strobe_decode (
  input  logic strobe_p_ni,
  input  logic strobe_c_ni,
  input  logic chip_sel_i,
  input  logic adv_ni,
  output logic load_o,
  output logic adv_o
);
  logic p_load, c_load;

  always_comb begin
    c_load = ~strobe_c_ni;
    p_load = ~strobe_p_ni & chip_sel_i;
    load_o = c_load | p_load;
    // load wins over advance
    adv_o  = ~adv_ni & ~load_o;
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  localparam logic [BEAT_W-1:0] BEAT_MAX = {BEAT_W{1'b1}};

  logic [BEAT_W-1:0] beat_q, beat_d;

  always_comb begin
    beat_d = beat_q;
    if (load_i)                         beat_d = '0;
    else if (adv_i && beat_q != BEAT_MAX) beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= '0;
    else         beat_q <= beat_d;
  end

  assign beat_o = beat_q;
  assign last_o = (beat_q == BEAT_MAX);

  assert_load_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_o == '0);
  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && !last_o) |=> beat_o == $past(beat_o) + 1'b1);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(beat_o));
  assert_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && last_o) |=> last_o);
endmodule

// File: rtl/addr_capture.sv
module addr_capture
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] base_o,
  output burst_order_e      order_o
);
  logic [ADDR_W-1:0] base_q;
  burst_order_e      order_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= ORD_LINEAR;
    end else begin
      if (load_i) base_q <= addr_i;
      order_q <= burst_order_e'(mode_i);
    end
  end

  assign base_o  = base_q;
  assign order_o = order_q;

  assert_base_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_o));
endmodule

// File: rtl/order_map.sv
module order_map
  import burst_addr_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin, ilv;

  always_comb begin
    lin   = start_i + beat_i;  // wraps inside the aligned block
    ilv   = start_i ^ beat_i;
    low_o = (order_i == ORD_INTERLEAVE) ? ilv : lin;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_p_ni,
  input  logic              strobe_c_ni,
  input  logic              chip_sel_i,
  input  logic              adv_ni,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  logic              load, adv;
  logic [ADDR_W-1:0] base;
  burst_order_e      order;
  logic [BEAT_W-1:0] low;

  strobe_decode i_strobe_decode (
    .strobe_p_ni (strobe_p_ni),
    .strobe_c_ni (strobe_c_ni),
    .chip_sel_i  (chip_sel_i),
    .adv_ni      (adv_ni),
    .load_o      (load),
    .adv_o       (adv)
  );

  addr_capture #(.ADDR_W(ADDR_W)) i_addr_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (addr_i),
    .mode_i  (mode_i),
    .base_o  (base),
    .order_o (order)
  );

  beat_counter #(.BEAT_W(BEAT_W)) i_beat_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (adv),
    .beat_o (beat_o),
    .last_o (last_o)
  );

  order_map #(.BEAT_W(BEAT_W)) i_order_map (
    .start_i (base[BEAT_W-1:0]),
    .beat_i  (beat_o),
    .order_i (order),
    .low_o   (low)
  );

  assign addr_o = {base[ADDR_W-1:BEAT_W], low};

  assert_c_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_c_ni |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_i[ADDR_W-1:BEAT_W])) && beat_o == '0);
  assert_p_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_c_ni && !chip_sel_i && adv_ni) |=> $stable(addr_o[ADDR_W-1:BEAT_W]) && $stable(beat_o));
  assert_linear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !last_o && order == ORD_LINEAR && !mode_i)
    |=> addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + 1'b1);
  assert_interleave_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !last_o && order == ORD_INTERLEAVE && mode_i)
    |=> (addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) == (beat_o ^ $past(beat_o)));
  assert_last_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(last_o) |-> beat_o == {BEAT_W{1'b1}});
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              strobe_p_ni = 1'b1, strobe_c_ni = 1'b1, chip_sel_i = 1'b0;
  logic              adv_ni = 1'b1, mode_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic [1:0]        beat_o;
  logic              last_o;

  int checks = 0, failures = 0;
  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0]        m_beat = '0;
  logic              m_mode = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) i_burst_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i),
    .strobe_p_ni(strobe_p_ni), .strobe_c_ni(strobe_c_ni), .chip_sel_i(chip_sel_i),
    .adv_ni(adv_ni), .mode_i(mode_i),
    .addr_o(addr_o), .beat_o(beat_o), .last_o(last_o)
  );

  function automatic logic [ADDR_W-1:0] exp_addr();
    logic [1:0] lo;
    lo = m_mode ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[ADDR_W-1:2], lo};
  endfunction

  task automatic compare(string tag);
    logic [ADDR_W-1:0] ea;
    ea = exp_addr();
    checks++;
    if (addr_o !== ea || beat_o !== m_beat || last_o !== (m_beat == 2'd3)) begin
      failures++;
      $display("FAIL %s: addr=%h beat=%0d last=%b expected addr=%h beat=%0d last=%b",
               tag, addr_o, beat_o, last_o, ea, m_beat, (m_beat == 2'd3));
    end
  endtask

  task automatic cycle(input logic p_n, input logic c_n, input logic cs, input logic a_n,
                       input logic md, input logic [ADDR_W-1:0] ad, input string tag);
    logic ld;
    @(negedge clk);
    strobe_p_ni = p_n; strobe_c_ni = c_n; chip_sel_i = cs;
    adv_ni = a_n; mode_i = md; addr_i = ad;
    @(posedge clk);
    ld = !c_n || (!p_n && cs);
    if (ld) begin m_base = ad; m_beat = '0; end
    else if (!a_n && m_beat != 2'd3) m_beat = m_beat + 2'd1;
    m_mode = md;
    #1 compare(tag);
  endtask

  initial begin
    #150000;
    failures++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a;
    void'($urandom(32'd2024));
    #5;
    compare("R1 in reset");
    rst_ni = 1'b1;
    cycle(1, 1, 0, 1, 0, '0, "R1 idle after reset");

    for (int md = 0; md < 2; md++) begin
      for (int off = 0; off < 4; off++) begin
        a = {$urandom} % (1 << ADDR_W);
        a[1:0] = off[1:0];
        cycle(1, 0, 0, 1, md[0], a, "R2 controller load");
        cycle(1, 1, 0, 0, md[0], '0, "R4 first advance");
        cycle(1, 1, 0, 0, md[0], '0, md ? "R9 interleaved beat" : "R8 linear beat");
        cycle(1, 1, 0, 0, md[0], '0, "R11 last beat");
        cycle(1, 1, 0, 0, md[0], '0, "R7 advance after last");
        cycle(1, 1, 1, 0, md[0], '0, "R10 upper bits held");
      end
    end

    cycle(0, 1, 0, 1, 0, 20'hABCDE, "R3 processor strobe without select");
    cycle(0, 1, 1, 1, 0, 20'h12345, "R3 processor strobe with select");
    cycle(1, 1, 0, 0, 0, '0, "R4 advance");
    cycle(1, 1, 0, 1, 0, '0, "R5 hold without advance");
    cycle(1, 1, 0, 1, 1, '0, "R9 order switch mid burst");
    cycle(0, 1, 0, 0, 1, 20'h0F0F3, "R3 ungated strobe lets advance run");
    cycle(1, 0, 0, 0, 1, 20'h55552, "R6 load beats advance");
    cycle(0, 1, 1, 0, 0, 20'h0AAA1, "R6 processor load beats advance");

    for (int i = 0; i < 400; i++) begin
      cycle(($urandom % 4) != 0, ($urandom % 6) != 0, $urandom % 2,
            ($urandom % 4) == 0, ($urandom % 8) == 0 ? ~mode_i : mode_i,
            {$urandom} % (1 << ADDR_W), "R10 random traffic");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule